// File: doc/BRIEF.md
# Fractional-N Ratio Source Selector

This block produces the control word for a delta-sigma fractional-N synthesizer. The word comes either from a stored user ratio, which gives plain frequency synthesis from the timing reference, or from the ratio word that a digital PLL computes while it tracks an external frequency reference, which gives hybrid jitter-cleaning operation. The source can follow the presence of that reference automatically, or it can be set by configuration. A multi-purpose mode pin can override the choice, force manual selection, or enable a power-of-two divide of the user ratio.

Four 32-bit user ratios arrive on one flat bus. Two index pins pick the ratio for static operation. In automatic mode a configuration pointer picks the ratio that the digital PLL should track. Every output word uses one format, 20.12 fixed point, so the modulator downstream never needs a format switch. The block also gives the digital PLL its normalized target ratio. It issues a one-cycle relock request whenever the chosen source or ratio changes, and it holds an unlocked flag until the loop reports lock again.

Top module: `ratio_src_sel`

## Requirements
- R1: While reset is asserted, `fracn_word` and `pll_target` are 0, `dyn_active` is 0, `relock_req` is 0 and `unlocked` is 1.
- R2: In static operation, `fracn_word` equals entry `mode_sel` of the table, read as 12.20 and shifted right by 8 into 20.12, whatever `cfg_hi_mult` says. Entry i sits at bits 32i+31:32i. Low bits are truncated, and outputs follow the inputs one clock later.
- R3: `pll_target` is the target entry, taken unchanged when `cfg_hi_mult`=1 (20.12) and shifted right by 8 when `cfg_hi_mult`=0 (12.20).
- R4: Automatic mode is on when `cfg_auto_en`=1 and manual selection is not forced. In automatic mode `dyn_active` follows `ref_present`, the target entry is `cfg_auto_idx`, and the static entry stays `mode_sel`.
- R5: In manual mode `dyn_active` equals `cfg_dyn_pref`. The exception is `cfg_pin_func`=3'b110, where it equals `aux_pin`. The target entry is `mode_sel`. When `dyn_active` is 1, `fracn_word` equals `dyn_word` unchanged.
- R6: With `cfg_pin_func`=3'b100, a high `aux_pin` forces manual mode even when `cfg_auto_en`=1. A low `aux_pin` leaves automatic mode in force.
- R7: With `cfg_pin_func`=3'b011 and `aux_pin` high, the static word and `pll_target` are shifted right by a further `cfg_shift_sel`+1 bits, and the dropped bits are discarded. `dyn_word` is never shifted. With any other `cfg_pin_func`, or with `aux_pin` low, no shift is applied.
- R8: `relock_req` is high for exactly the cycle after a change of the source or of the selected entry. The selected entry is the target entry when the source is dynamic and `mode_sel` when it is static. A change in the shift or in `dyn_word` raises no request.
- R9: `unlocked` is set together with `relock_req` and stays high until `loop_locked` is seen high in a cycle with no new request. It clears one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_tbl | input | 128 | Four user ratios, entry i at bits 32i+31:32i |
| mode_sel | input | 2 | Index pins for the static ratio |
| aux_pin | input | 1 | Multi-purpose mode pin |
| ref_present | input | 1 | External frequency reference detected |
| cfg_auto_en | input | 1 | Enable automatic source selection |
| cfg_auto_idx | input | 2 | Target entry used in automatic mode |
| cfg_dyn_pref | input | 1 | Manual source choice, 1 = dynamic |
| cfg_pin_func | input | 3 | Function of `aux_pin` |
| cfg_shift_sel | input | 2 | Extra right shift minus one |
| cfg_hi_mult | input | 1 | Target ratio format, 1 = 20.12, 0 = 12.20 |
| dyn_word | input | 32 | Ratio word from the digital PLL, 20.12 |
| loop_locked | input | 1 | Loop reports lock |
| fracn_word | output | 32 | Control word to the modulator, 20.12 |
| pll_target | output | 32 | Normalized target ratio for the digital PLL |
| dyn_active | output | 1 | Dynamic source in use |
| relock_req | output | 1 | One-cycle relock request |
| unlocked | output | 1 | Held unlock status |

## Verification
Some rules are checked by the assertions on every cycle:
- the source decision under automatic control and under forced manual control;
- the unchanged passing of the loop's word whenever the dynamic source is active;
- a relock request whenever the source flips;
- the clearing of the unlocked flag after a lock report.

Other behaviour can only be shown by the bench's scenarios, with a known ratio table:
- the arithmetic of format conversion, including bits truncated to zero;
- the pin-enabled shift, and the fact that it leaves the dynamic word alone;
- the absence of a relock request on shift-only changes;
- the priority of a new request over a lock report.

// File: rtl/ratio_sel_pkg.sv
package ratio_sel_pkg;

    // Codes of the multi-purpose pin function field that this block decodes
    localparam logic [2:0] PIN_SHIFT_EN  = 3'b011;
    localparam logic [2:0] PIN_FORCE_MAN = 3'b100;
    localparam logic [2:0] PIN_SRC_OVR   = 3'b110;

    // Fraction widths of the two stored formats and of the output format
    localparam int FRAC_HIRES = 20;
    localparam int FRAC_OUT   = 12;

endpackage

// File: rtl/src_decide.sv
module src_decide
    import ratio_sel_pkg::*;
#(
    parameter int IDXW = 2
) (
    input  logic [IDXW-1:0] mode_sel,
    input  logic            aux_pin,
    input  logic            ref_present,
    input  logic            cfg_auto_en,
    input  logic [IDXW-1:0] cfg_auto_idx,
    input  logic            cfg_dyn_pref,
    input  logic [2:0]      cfg_pin_func,
    output logic            use_dyn,
    output logic [IDXW-1:0] tgt_idx,
    output logic            shift_on
);
    logic forced_man;
    logic auto_on;
    logic man_dyn;

    always_comb begin
        forced_man = (cfg_pin_func == PIN_FORCE_MAN) && aux_pin;
        auto_on    = cfg_auto_en && !forced_man;
        man_dyn    = (cfg_pin_func == PIN_SRC_OVR) ? aux_pin : cfg_dyn_pref;
        use_dyn    = auto_on ? ref_present : man_dyn;
        tgt_idx    = auto_on ? cfg_auto_idx : mode_sel;
        shift_on   = (cfg_pin_func == PIN_SHIFT_EN) && aux_pin;
    end

endmodule

// File: rtl/ratio_pick.sv
module ratio_pick #(
    parameter int W    = 32,
    parameter int NUM  = 4,
    localparam int IDXW = $clog2(NUM)
) (
    input  logic [NUM*W-1:0] tbl,
    input  logic [IDXW-1:0]  idx,
    output logic [W-1:0]     word
);
    logic [W-1:0] entry [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_unpack
        assign entry[g] = tbl[g*W +: W];
    end

    assign word = entry[idx];

endmodule

// File: rtl/word_norm.sv
module word_norm #(
    parameter int W       = 32,
    parameter int NORM_SH = 8,
    parameter int SSW     = 2
) (
    input  logic [W-1:0]   raw,
    input  logic           hi_mult,
    input  logic           shift_on,
    input  logic [SSW-1:0] shift_sel,
    output logic [W-1:0]   norm
);
    localparam int AMTW = SSW + 1;

    logic [W-1:0]    base;
    logic [AMTW-1:0] amt;

    always_comb begin
        base = hi_mult ? raw : (raw >> NORM_SH);
        amt  = {1'b0, shift_sel} + AMTW'(1);
        norm = shift_on ? (base >> amt) : base;
    end

endmodule

// File: rtl/ratio_src_sel.sv
module ratio_src_sel
    import ratio_sel_pkg::*;
#(
    parameter int W    = 32,
    parameter int NUM  = 4,
    parameter int SSW  = 2,
    localparam int IDXW = $clog2(NUM),
    localparam int NSH  = FRAC_HIRES - FRAC_OUT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NUM*W-1:0] ratio_tbl,
    input  logic [IDXW-1:0] mode_sel,
    input  logic            aux_pin,
    input  logic            ref_present,
    input  logic            cfg_auto_en,
    input  logic [IDXW-1:0] cfg_auto_idx,
    input  logic            cfg_dyn_pref,
    input  logic [2:0]      cfg_pin_func,
    input  logic [SSW-1:0]  cfg_shift_sel,
    input  logic            cfg_hi_mult,
    input  logic [W-1:0]    dyn_word,
    input  logic            loop_locked,
    output logic [W-1:0]    fracn_word,
    output logic [W-1:0]    pll_target,
    output logic            dyn_active,
    output logic            relock_req,
    output logic            unlocked
);
    typedef struct packed {
        logic [W-1:0]    fw;
        logic [W-1:0]    pt;
        logic            dyn;
        logic [IDXW-1:0] idx;
        logic            relock;
        logic            unlk;
    } state_t;

    state_t st_d, st_q;

    logic            use_dyn;
    logic [IDXW-1:0] tgt_idx;
    logic            shift_on;
    logic [W-1:0]    stat_raw, tgt_raw;
    logic [W-1:0]    stat_norm, tgt_norm;

    src_decide #(.IDXW(IDXW)) u_decide (
        .mode_sel     (mode_sel),
        .aux_pin      (aux_pin),
        .ref_present  (ref_present),
        .cfg_auto_en  (cfg_auto_en),
        .cfg_auto_idx (cfg_auto_idx),
        .cfg_dyn_pref (cfg_dyn_pref),
        .cfg_pin_func (cfg_pin_func),
        .use_dyn      (use_dyn),
        .tgt_idx      (tgt_idx),
        .shift_on     (shift_on)
    );

    ratio_pick #(.W(W), .NUM(NUM)) u_pick_stat (
        .tbl  (ratio_tbl),
        .idx  (mode_sel),
        .word (stat_raw)
    );

    ratio_pick #(.W(W), .NUM(NUM)) u_pick_tgt (
        .tbl  (ratio_tbl),
        .idx  (tgt_idx),
        .word (tgt_raw)
    );

    // Static operation always reads the stored ratio as high resolution
    word_norm #(.W(W), .NORM_SH(NSH), .SSW(SSW)) u_norm_stat (
        .raw       (stat_raw),
        .hi_mult   (1'b0),
        .shift_on  (shift_on),
        .shift_sel (cfg_shift_sel),
        .norm      (stat_norm)
    );

    word_norm #(.W(W), .NORM_SH(NSH), .SSW(SSW)) u_norm_tgt (
        .raw       (tgt_raw),
        .hi_mult   (cfg_hi_mult),
        .shift_on  (shift_on),
        .shift_sel (cfg_shift_sel),
        .norm      (tgt_norm)
    );

    always_comb begin
        logic changed;
        st_d     = st_q;
        st_d.dyn = use_dyn;
        st_d.fw  = use_dyn ? dyn_word : stat_norm;
        st_d.pt  = tgt_norm;
        st_d.idx = use_dyn ? tgt_idx : mode_sel;
        changed  = (st_d.dyn != st_q.dyn) || (st_d.idx != st_q.idx);
        st_d.relock = changed;
        if (changed) begin
            st_d.unlk = 1'b1;
        end else if (loop_locked) begin
            st_d.unlk = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{fw: '0, pt: '0, dyn: 1'b0, idx: '0, relock: 1'b0, unlk: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign fracn_word = st_q.fw;
    assign pll_target = st_q.pt;
    assign dyn_active = st_q.dyn;
    assign relock_req = st_q.relock;
    assign unlocked   = st_q.unlk;

endmodule

// File: rtl/ratio_src_sel_chk.sv
module ratio_src_sel_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         aux_pin,
    input logic         ref_present,
    input logic         cfg_auto_en,
    input logic         cfg_dyn_pref,
    input logic [2:0]   cfg_pin_func,
    input logic [W-1:0] dyn_word,
    input logic         loop_locked,
    input logic [W-1:0] fracn_word,
    input logic         dyn_active,
    input logic         relock_req,
    input logic         unlocked
);
    // R4: automatic control follows reference presence
    a_r4_auto_follows_ref: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_auto_en && cfg_pin_func != 3'b100) |=> (dyn_active == $past(ref_present)));

    // R6: pin-forced manual with static preference gives static source
    a_r6_forced_manual: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_pin_func == 3'b100 && aux_pin && !cfg_dyn_pref) |=> !dyn_active);

    // R5: dynamic word passes unchanged
    a_r5_dyn_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        dyn_active |-> (fracn_word == $past(dyn_word)));

    // R8: a source flip raises a request
    a_r8_flip_relock: assert property (@(posedge clk) disable iff (!rst_n)
        (dyn_active != $past(dyn_active)) |-> relock_req);

    // R9: request implies unlocked
    a_r9_relock_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        relock_req |-> unlocked);

    // R9: lock report with no new request clears the flag
    a_r9_lock_clears: assert property (@(posedge clk) disable iff (!rst_n)
        loop_locked ##1 !relock_req |-> !unlocked);

endmodule

bind ratio_src_sel ratio_src_sel_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .aux_pin      (aux_pin),
    .ref_present  (ref_present),
    .cfg_auto_en  (cfg_auto_en),
    .cfg_dyn_pref (cfg_dyn_pref),
    .cfg_pin_func (cfg_pin_func),
    .dyn_word     (dyn_word),
    .loop_locked  (loop_locked),
    .fracn_word   (fracn_word),
    .dyn_active   (dyn_active),
    .relock_req   (relock_req),
    .unlocked     (unlocked)
);

// File: tb/ratio_src_sel_bench.sv
`timescale 1ns/1ps
module ratio_src_sel_bench;

    localparam logic [31:0] RA0 = 32'h0100_0000;
    localparam logic [31:0] RA1 = 32'h0020_0000;
    localparam logic [31:0] RA2 = 32'h0003_0000;
    localparam logic [31:0] RA3 = 32'h0000_00FF;
    localparam logic [31:0] DYN = 32'hABCD_1234;
    localparam int NV = 14;

    // {mode_sel, aux, present, auto_en, auto_idx, pref, pin_func, shift_sel, hi_mult, exp_dyn, exp_fw, exp_pt}
    localparam logic [78:0] VEC [NV] = '{
        {2'd0,1'b0,1'b0,1'b0,2'd0,1'b0,3'b000,2'd0,1'b0, 1'b0, 32'h0001_0000, 32'h0001_0000}, // R2
        {2'd1,1'b0,1'b0,1'b0,2'd0,1'b0,3'b000,2'd0,1'b1, 1'b0, 32'h0000_2000, 32'h0020_0000}, // R2 R3
        {2'd2,1'b0,1'b0,1'b0,2'd0,1'b1,3'b000,2'd0,1'b0, 1'b1, DYN,           32'h0000_0300}, // R5
        {2'd3,1'b0,1'b0,1'b0,2'd0,1'b0,3'b000,2'd0,1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000}, // R2 truncation
        {2'd0,1'b0,1'b1,1'b1,2'd1,1'b0,3'b000,2'd0,1'b1, 1'b1, DYN,           32'h0020_0000}, // R4
        {2'd2,1'b0,1'b0,1'b1,2'd1,1'b0,3'b000,2'd0,1'b1, 1'b0, 32'h0000_0300, 32'h0020_0000}, // R4
        {2'd0,1'b1,1'b0,1'b0,2'd0,1'b0,3'b110,2'd0,1'b0, 1'b1, DYN,           32'h0001_0000}, // R5 pin override
        {2'd0,1'b0,1'b0,1'b0,2'd0,1'b0,3'b110,2'd0,1'b0, 1'b0, 32'h0001_0000, 32'h0001_0000}, // R5
        {2'd1,1'b1,1'b1,1'b1,2'd3,1'b0,3'b100,2'd0,1'b0, 1'b0, 32'h0000_2000, 32'h0000_2000}, // R6
        {2'd0,1'b1,1'b0,1'b0,2'd0,1'b0,3'b011,2'd0,1'b0, 1'b0, 32'h0000_8000, 32'h0000_8000}, // R7
        {2'd1,1'b1,1'b0,1'b0,2'd0,1'b0,3'b011,2'd3,1'b1, 1'b0, 32'h0000_0200, 32'h0002_0000}, // R7
        {2'd1,1'b0,1'b0,1'b0,2'd0,1'b0,3'b011,2'd3,1'b1, 1'b0, 32'h0000_2000, 32'h0020_0000}, // R7 pin low
        {2'd0,1'b1,1'b0,1'b0,2'd0,1'b1,3'b011,2'd1,1'b0, 1'b1, DYN,           32'h0000_4000}, // R7 dyn unshifted
        {2'd0,1'b0,1'b1,1'b1,2'd2,1'b0,3'b100,2'd0,1'b0, 1'b1, DYN,           32'h0000_0300}  // R6 pin low
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_sel = '0;
    logic        aux_pin = 1'b0;
    logic        ref_present = 1'b0;
    logic        cfg_auto_en = 1'b0;
    logic [1:0]  cfg_auto_idx = '0;
    logic        cfg_dyn_pref = 1'b0;
    logic [2:0]  cfg_pin_func = '0;
    logic [1:0]  cfg_shift_sel = '0;
    logic        cfg_hi_mult = 1'b0;
    logic [31:0] dyn_word = DYN;
    logic        loop_locked = 1'b0;
    logic [31:0] fracn_word, pll_target;
    logic        dyn_active, relock_req, unlocked;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    ratio_src_sel u_ratio_src_sel (
        .clk (clk), .rst_n (rst_n),
        .ratio_tbl ({RA3, RA2, RA1, RA0}),
        .mode_sel (mode_sel), .aux_pin (aux_pin), .ref_present (ref_present),
        .cfg_auto_en (cfg_auto_en), .cfg_auto_idx (cfg_auto_idx),
        .cfg_dyn_pref (cfg_dyn_pref), .cfg_pin_func (cfg_pin_func),
        .cfg_shift_sel (cfg_shift_sel), .cfg_hi_mult (cfg_hi_mult),
        .dyn_word (dyn_word), .loop_locked (loop_locked),
        .fracn_word (fracn_word), .pll_target (pll_target),
        .dyn_active (dyn_active), .relock_req (relock_req), .unlocked (unlocked)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one clock: inputs were set at a falling edge, sample at the next falling edge
    task automatic step();
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        chk("R1", "fracn_word", fracn_word, 32'h0);
        chk("R1", "pll_target", pll_target, 32'h0);
        chk("R1", "dyn_active", {31'b0, dyn_active}, 32'h0);
        chk("R1", "relock_req", {31'b0, relock_req}, 32'h0);
        chk("R1", "unlocked",   {31'b0, unlocked},   32'h1);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            {mode_sel, aux_pin, ref_present, cfg_auto_en, cfg_auto_idx, cfg_dyn_pref,
             cfg_pin_func, cfg_shift_sel, cfg_hi_mult} = VEC[i][78:65];
            step();
            chk("R2-R7 vec", "dyn_active", {31'b0, dyn_active}, {31'b0, VEC[i][64]});
            chk("R2-R7 vec", "fracn_word", fracn_word, VEC[i][63:32]);
            chk("R2-R7 vec", "pll_target", pll_target, VEC[i][31:0]);
        end

        // R8 / R9 directed: settle static entry 0 and report lock
        {mode_sel, aux_pin, ref_present, cfg_auto_en, cfg_auto_idx, cfg_dyn_pref,
         cfg_pin_func, cfg_shift_sel, cfg_hi_mult} = '0;
        loop_locked = 1'b1;
        step(); step();
        chk("R9", "unlocked after lock", {31'b0, unlocked}, 32'h0);
        chk("R8", "no relock when steady", {31'b0, relock_req}, 32'h0);

        mode_sel = 2'd1;
        step();
        chk("R8", "relock on index change", {31'b0, relock_req}, 32'h1);
        chk("R9", "request wins over lock", {31'b0, unlocked}, 32'h1);
        step();
        chk("R8", "relock one cycle", {31'b0, relock_req}, 32'h0);
        chk("R9", "lock clears flag", {31'b0, unlocked}, 32'h0);

        loop_locked = 1'b0;
        cfg_dyn_pref = 1'b1;
        step();
        chk("R8", "relock on source change", {31'b0, relock_req}, 32'h1);
        chk("R9", "unlocked set", {31'b0, unlocked}, 32'h1);
        step();
        chk("R9", "unlocked held", {31'b0, unlocked}, 32'h1);

        // R8: shift or dynamic word changes raise no request
        cfg_pin_func = 3'b011;
        aux_pin = 1'b1;
        cfg_shift_sel = 2'd2;
        dyn_word = 32'h1111_2222;
        step();
        chk("R8", "no relock on shift change", {31'b0, relock_req}, 32'h0);
        chk("R7", "dyn word not shifted", fracn_word, 32'h1111_2222);
        chk("R7", "target shifted by 3", pll_target, 32'h0000_0400);

        loop_locked = 1'b1;
        step();
        chk("R9", "lock clears after hold", {31'b0, unlocked}, 32'h0);

        // R1: reset in the middle of operation
        rst_n = 1'b0;
        #1;
        chk("R1", "async reset word", fracn_word, 32'h0);
        chk("R1", "async reset unlocked", {31'b0, unlocked}, 32'h1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule